// File: doc/BRIEF.md
# Clock Lane Transmit Sequencer

This block sequences the line state of a D-PHY clock lane through each low-power to high-speed entry and back. It runs on a timing clock of known period. Every timing minimum is a parameter given in picoseconds or in unit intervals (UI). At elaboration these minimums are turned into whole cycle counts by ceiling division, so each phase lasts at least its minimum and is never cut short by rounding.

A data-lane controller raises `hs_req_i` to ask for a high-speed clock. It then waits for `clk_ready_o` before it takes its own lanes out of LP. When every data lane has finished its trail and is back in LP, the controller drops the request and reports `data_lp_i`. The sequencer then keeps the clock toggling for the post window, drives the trail and returns the lane to LP-11. The optional output register (`OUT_REG`) delays every output by the same number of cycles, so phase lengths stay the same whichever variant is built.

Top module: `dphy_clk_lane_seq`

## Requirements
- R1: Entry order is LP-11, then LP-01, then LP-00 prepare, then HS-0 zero, then the toggling clock. The outputs encode these as {lp_p_o, lp_n_o, hs_en_o, hs_clk_run_o, clk_ready_o}: LP-11 = 11000, LP-01 = 01000, LP-00 = 00000, HS-0 = 00100, clock running without ready = 00110, clock running with ready = 00111. An accepted request leaves LP-11 within two cycles.
- R2: LP-01 lasts exactly ceil(LPX_PS/CLK_PERIOD_PS) cycles, which is at least 50 ns.
- R3: LP-00 prepare lasts ceil(PREP_MIN_PS/period) cycles, which falls within 38 ns to 95 ns. A configuration that would exceed 95 ns fails elaboration.
- R4: Prepare plus HS-0 zero together last ceil(PREP_ZERO_PS/period) cycles, which is at least 300 ns.
- R5: The clock toggles for ceil(PRE_UI*UI_PS/period) cycles (at least 8 UI) with clk_ready_o low before clk_ready_o rises.
- R6: clk_ready_o is high only while the clock is running. It falls no more than two cycles after the exit condition is applied.
- R7: From the ready state, the exit starts only when data_lp_i is high and hs_req_i is low. Any other input combination keeps the clock running with ready high.
- R8: After exit starts, the clock keeps toggling without ready for exactly ceil((POST_PS+POST_UI*UI_PS)/period) cycles, which is at least 60 ns + 52 UI.
- R9: The trail HS-0 lasts ceil(TRAIL_PS/period) cycles, which is at least 60 ns. The lane then returns to LP-11.
- R10: LP-11 is held for at least ceil(LPX_PS/period) cycles after reset and after each exit before a new entry starts. The outputs read LP-11 during reset.
- R11: A request raised and dropped while the sequencer is not in idle LP-11 has no effect. The lane stays in LP-11 afterwards.
- R12: hs_en_o high implies LP pair 00, and hs_clk_run_o high implies hs_en_o high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timing clock, period CLK_PERIOD_PS |
| rst_n | input | 1 | Active-low asynchronous reset |
| hs_req_i | input | 1 | Level request for a high-speed clock burst |
| data_lp_i | input | 1 | All associated data lanes are in LP |
| lp_p_o | output | 1 | LP driver level, positive wire |
| lp_n_o | output | 1 | LP driver level, negative wire |
| hs_en_o | output | 1 | HS driver enabled (HS-0 or toggling) |
| hs_clk_run_o | output | 1 | HS clock is toggling |
| clk_ready_o | output | 1 | Data lanes may start their LP-to-HS entry |

## Verification
The bench runs repeated bursts with different run lengths and measures the length of every phase at the outputs. It compares each length with ceilings computed from the nanosecond and UI minimums. A design that rounds down would give a prepare or post window one cycle short, and an off-by-one counter would change every measured length. In the ready state the bench applies the input combinations that must not end the burst, so a design that exits on either input alone would cut the clock while data is still moving. The bench also pulses the request during post and trail, and starts a new request the moment LP-11 reappears. A design that latches early requests would re-enter unprompted, and one that skips the LP-11 hold would show an LP-11 phase shorter than the minimum.

// File: rtl/dcl_pkg.sv
package dcl_pkg;

   typedef enum logic [3:0] {
      S_HOLD11 = 4'd0,
      S_IDLE   = 4'd1,
      S_LPREQ  = 4'd2,
      S_PREP   = 4'd3,
      S_ZERO   = 4'd4,
      S_PRE    = 4'd5,
      S_RUN    = 4'd6,
      S_POST   = 4'd7,
      S_TRAIL  = 4'd8
   } state_e;

   typedef struct packed {
      logic lp_p;
      logic lp_n;
      logic hs_en;
      logic clk_run;
      logic ready;
   } line_t;

   localparam line_t LINE_IDLE = '{lp_p: 1'b1, lp_n: 1'b1, hs_en: 1'b0,
                                   clk_run: 1'b0, ready: 1'b0};

   // ceiling division, never below one cycle
   function automatic int cdiv(input int num, input int den);
      int q;
      q = (num + den - 1) / den;
      return (q < 1) ? 1 : q;
   endfunction

   function automatic int imax(input int a, input int b);
      return (a > b) ? a : b;
   endfunction

endpackage

// File: rtl/dcl_timer.sv
module dcl_timer #(
   parameter int CW      = 8,
   parameter int RST_VAL = 0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic [CW-1:0] load_val_i,
   output logic          done_o
);

   logic [CW-1:0] cnt_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt_q <= CW'(RST_VAL);
      else if (load_i)        cnt_q <= load_val_i;
      else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
   end

   assign done_o = (cnt_q == '0);

endmodule

// File: rtl/dcl_fsm.sv
module dcl_fsm
   import dcl_pkg::*;
#(
   parameter int CW      = 8,
   parameter int LPX_C   = 13,
   parameter int PREP_C  = 10,
   parameter int ZERO_C  = 65,
   parameter int PRE_C   = 1,
   parameter int POST_C  = 22,
   parameter int TRAIL_C = 15
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          hs_req_i,
   input  logic          data_lp_i,
   input  logic          done_i,
   output state_e        state_o,
   output logic          load_o,
   output logic [CW-1:0] load_val_o
);

   state_e st_q, st_d;

   always_comb begin
      st_d       = st_q;
      load_o     = 1'b0;
      load_val_o = '0;
      unique case (st_q)
         S_HOLD11: if (done_i) st_d = S_IDLE;
         S_IDLE: if (hs_req_i) begin
            st_d = S_LPREQ; load_o = 1'b1; load_val_o = CW'(LPX_C - 1);
         end
         S_LPREQ: if (done_i) begin
            st_d = S_PREP; load_o = 1'b1; load_val_o = CW'(PREP_C - 1);
         end
         S_PREP: if (done_i) begin
            st_d = S_ZERO; load_o = 1'b1; load_val_o = CW'(ZERO_C - 1);
         end
         S_ZERO: if (done_i) begin
            st_d = S_PRE; load_o = 1'b1; load_val_o = CW'(PRE_C - 1);
         end
         S_PRE: if (done_i) st_d = S_RUN;
         S_RUN: if (data_lp_i && !hs_req_i) begin
            st_d = S_POST; load_o = 1'b1; load_val_o = CW'(POST_C - 1);
         end
         S_POST: if (done_i) begin
            st_d = S_TRAIL; load_o = 1'b1; load_val_o = CW'(TRAIL_C - 1);
         end
         S_TRAIL: if (done_i) begin
            st_d = S_HOLD11; load_o = 1'b1; load_val_o = CW'(LPX_C - 1);
         end
         default: st_d = S_HOLD11;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) st_q <= S_HOLD11;
      else        st_q <= st_d;
   end

   assign state_o = st_q;

endmodule

// File: rtl/dcl_line_enc.sv
module dcl_line_enc
   import dcl_pkg::*;
#(
   parameter bit OUT_REG = 1'b1
) (
   input  logic   clk,
   input  logic   rst_n,
   input  state_e state_i,
   output line_t  line_o
);

   line_t line_d;

   always_comb begin
      line_d = LINE_IDLE;
      unique case (state_i)
         S_HOLD11, S_IDLE: line_d = LINE_IDLE;
         S_LPREQ: line_d = '{lp_p: 1'b0, lp_n: 1'b1, hs_en: 1'b0, clk_run: 1'b0, ready: 1'b0};
         S_PREP:  line_d = '{lp_p: 1'b0, lp_n: 1'b0, hs_en: 1'b0, clk_run: 1'b0, ready: 1'b0};
         S_ZERO, S_TRAIL:
                  line_d = '{lp_p: 1'b0, lp_n: 1'b0, hs_en: 1'b1, clk_run: 1'b0, ready: 1'b0};
         S_PRE, S_POST:
                  line_d = '{lp_p: 1'b0, lp_n: 1'b0, hs_en: 1'b1, clk_run: 1'b1, ready: 1'b0};
         S_RUN:   line_d = '{lp_p: 1'b0, lp_n: 1'b0, hs_en: 1'b1, clk_run: 1'b1, ready: 1'b1};
         default: line_d = LINE_IDLE;
      endcase
   end

   generate
      if (OUT_REG) begin : g_reg
         line_t line_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) line_q <= LINE_IDLE;
            else        line_q <= line_d;
         end
         assign line_o = line_q;
      end else begin : g_comb
         assign line_o = line_d;
      end
   endgenerate

endmodule

// File: rtl/dphy_clk_lane_seq.sv
module dphy_clk_lane_seq
   import dcl_pkg::*;
#(
   parameter int CLK_PERIOD_PS = 4000,
   parameter int UI_PS         = 500,
   parameter int LPX_PS        = 50000,
   parameter int PREP_MIN_PS   = 38000,
   parameter int PREP_MAX_PS   = 95000,
   parameter int PREP_ZERO_PS  = 300000,
   parameter int PRE_UI        = 8,
   parameter int POST_PS       = 60000,
   parameter int POST_UI       = 52,
   parameter int TRAIL_PS      = 60000,
   parameter bit OUT_REG       = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic hs_req_i,
   input  logic data_lp_i,
   output logic lp_p_o,
   output logic lp_n_o,
   output logic hs_en_o,
   output logic hs_clk_run_o,
   output logic clk_ready_o
);

   localparam int LPX_C   = cdiv(LPX_PS, CLK_PERIOD_PS);
   localparam int PREP_C  = cdiv(PREP_MIN_PS, CLK_PERIOD_PS);
   localparam int TOTZ_C  = cdiv(PREP_ZERO_PS, CLK_PERIOD_PS);
   localparam int ZERO_C  = (TOTZ_C > PREP_C) ? (TOTZ_C - PREP_C) : 1;
   localparam int PRE_C   = cdiv(PRE_UI * UI_PS, CLK_PERIOD_PS);
   localparam int POST_C  = cdiv(POST_PS + POST_UI * UI_PS, CLK_PERIOD_PS);
   localparam int TRAIL_C = cdiv(TRAIL_PS, CLK_PERIOD_PS);
   localparam int MAX_C   = imax(imax(imax(LPX_C, PREP_C), imax(ZERO_C, PRE_C)),
                                 imax(POST_C, TRAIL_C));
   localparam int CW      = $clog2(MAX_C + 1);

   generate
      if (CLK_PERIOD_PS <= 0 || UI_PS <= 0) begin : g_bad_period
         $error("clock period and UI must be positive");
      end
      if (PREP_C * CLK_PERIOD_PS > PREP_MAX_PS) begin : g_bad_prep
         $error("prepare window cannot be met at this clock period");
      end
   endgenerate

   state_e          state;
   logic            load;
   logic [CW-1:0]   load_val;
   logic            done;
   line_t           line;

   dcl_timer #(.CW(CW), .RST_VAL(LPX_C - 1)) u_timer (
      .clk        (clk),
      .rst_n      (rst_n),
      .load_i     (load),
      .load_val_i (load_val),
      .done_o     (done)
   );

   dcl_fsm #(
      .CW(CW), .LPX_C(LPX_C), .PREP_C(PREP_C), .ZERO_C(ZERO_C),
      .PRE_C(PRE_C), .POST_C(POST_C), .TRAIL_C(TRAIL_C)
   ) u_fsm (
      .clk        (clk),
      .rst_n      (rst_n),
      .hs_req_i   (hs_req_i),
      .data_lp_i  (data_lp_i),
      .done_i     (done),
      .state_o    (state),
      .load_o     (load),
      .load_val_o (load_val)
   );

   dcl_line_enc #(.OUT_REG(OUT_REG)) u_enc (
      .clk     (clk),
      .rst_n   (rst_n),
      .state_i (state),
      .line_o  (line)
   );

   assign lp_p_o       = line.lp_p;
   assign lp_n_o       = line.lp_n;
   assign hs_en_o      = line.hs_en;
   assign hs_clk_run_o = line.clk_run;
   assign clk_ready_o  = line.ready;

endmodule

// File: rtl/dcl_seq_chk.sv
module dcl_seq_chk #(
   parameter int CLK_PERIOD_PS = 4000,
   parameter int UI_PS         = 500,
   parameter int LPX_PS        = 50000,
   parameter int PREP_MIN_PS   = 38000,
   parameter int PREP_MAX_PS   = 95000,
   parameter int PRE_UI        = 8,
   parameter int POST_PS       = 60000,
   parameter int POST_UI       = 52,
   parameter int TRAIL_PS      = 60000
) (
   input logic clk,
   input logic rst_n,
   input logic lp_p_o,
   input logic lp_n_o,
   input logic hs_en_o,
   input logic hs_clk_run_o,
   input logic clk_ready_o
);

   localparam logic [4:0] C_IDLE = 5'b11000;
   localparam logic [4:0] C_LP01 = 5'b01000;
   localparam logic [4:0] C_PREP = 5'b00000;
   localparam logic [4:0] C_HS0  = 5'b00100;
   localparam logic [4:0] C_CLK  = 5'b00110;
   localparam logic [4:0] C_RDY  = 5'b00111;

   logic [4:0] code, prev_q;
   int         seg_q;
   logic       seg_end;

   assign code    = {lp_p_o, lp_n_o, hs_en_o, hs_clk_run_o, clk_ready_o};
   assign seg_end = (code != prev_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         prev_q <= C_IDLE;
         seg_q  <= 0;
      end else if (seg_end) begin
         prev_q <= code;
         seg_q  <= 1;
      end else if (seg_q < 1000000) begin
         seg_q  <= seg_q + 1;
      end
   end

   p_hs_lp00_r12: assert property (@(posedge clk) disable iff (!rst_n)
      hs_en_o |-> (!lp_p_o && !lp_n_o));
   p_run_en_r12: assert property (@(posedge clk) disable iff (!rst_n)
      hs_clk_run_o |-> hs_en_o);
   p_ready_run_r6: assert property (@(posedge clk) disable iff (!rst_n)
      clk_ready_o |-> hs_clk_run_o);
   p_lp01_first_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(lp_p_o) |-> (lp_n_o && !hs_en_o));
   p_hs_after_lp00_r1: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(hs_en_o) |-> $past(!lp_p_o && !lp_n_o));
   p_lpx_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_end && prev_q == C_LP01) |-> (seg_q * CLK_PERIOD_PS >= LPX_PS));
   p_prep_win_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_end && prev_q == C_PREP) |->
         (seg_q * CLK_PERIOD_PS >= PREP_MIN_PS && seg_q * CLK_PERIOD_PS <= PREP_MAX_PS));
   p_pre_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_end && prev_q == C_CLK && code == C_RDY) |->
         (seg_q * CLK_PERIOD_PS >= PRE_UI * UI_PS));
   p_post_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_end && prev_q == C_CLK && code == C_HS0) |->
         (seg_q * CLK_PERIOD_PS >= POST_PS + POST_UI * UI_PS));
   p_hs0_len_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_end && prev_q == C_HS0) |-> (seg_q * CLK_PERIOD_PS >= TRAIL_PS));
   p_idle_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (seg_end && prev_q == C_IDLE) |-> (seg_q * CLK_PERIOD_PS >= LPX_PS));

endmodule

bind dphy_clk_lane_seq dcl_seq_chk #(
   .CLK_PERIOD_PS (CLK_PERIOD_PS),
   .UI_PS         (UI_PS),
   .LPX_PS        (LPX_PS),
   .PREP_MIN_PS   (PREP_MIN_PS),
   .PREP_MAX_PS   (PREP_MAX_PS),
   .PRE_UI        (PRE_UI),
   .POST_PS       (POST_PS),
   .POST_UI       (POST_UI),
   .TRAIL_PS      (TRAIL_PS)
) u_chk (
   .clk          (clk),
   .rst_n        (rst_n),
   .lp_p_o       (lp_p_o),
   .lp_n_o       (lp_n_o),
   .hs_en_o      (hs_en_o),
   .hs_clk_run_o (hs_clk_run_o),
   .clk_ready_o  (clk_ready_o)
);

// File: tb/dphy_clk_lane_seq_tb_top.sv
`timescale 1ns/1ps
module dphy_clk_lane_seq_tb_top;

   localparam int P  = 4000;
   localparam int UI = 500;

   // expected cycle counts, from the nanosecond / UI minimums
   localparam int E_LPX   = (50000 + P - 1) / P;
   localparam int E_PREP  = (38000 + P - 1) / P;
   localparam int E_TOTZ  = (300000 + P - 1) / P;
   localparam int E_ZERO  = E_TOTZ - E_PREP;
   localparam int E_PRE   = (8 * UI + P - 1) / P;
   localparam int E_POST  = (60000 + 52 * UI + P - 1) / P;
   localparam int E_TRAIL = (60000 + P - 1) / P;

   localparam logic [4:0] C_IDLE = 5'b11000;
   localparam logic [4:0] C_LP01 = 5'b01000;
   localparam logic [4:0] C_PREP = 5'b00000;
   localparam logic [4:0] C_HS0  = 5'b00100;
   localparam logic [4:0] C_CLK  = 5'b00110;
   localparam logic [4:0] C_RDY  = 5'b00111;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic hs_req = 1'b0;
   logic data_lp = 1'b1;
   logic lp_p, lp_n, hs_en, clk_run, ready;

   int n_total = 0;
   int n_fail  = 0;

   always #2 clk = ~clk;

   dphy_clk_lane_seq #(.CLK_PERIOD_PS(P), .UI_PS(UI)) dut_i (
      .clk          (clk),
      .rst_n        (rst_n),
      .hs_req_i     (hs_req),
      .data_lp_i    (data_lp),
      .lp_p_o       (lp_p),
      .lp_n_o       (lp_n),
      .hs_en_o      (hs_en),
      .hs_clk_run_o (clk_run),
      .clk_ready_o  (ready)
   );

   function automatic logic [4:0] cur();
      return {lp_p, lp_n, hs_en, clk_run, ready};
   endfunction

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      n_total++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic measure(input logic [4:0] code, output int n);
      n = 0;
      while (cur() == code && n < 5000) begin
         n++;
         @(negedge clk);
      end
   endtask

   // one full burst; entered on a negedge with LP-11 visible
   task automatic burst(input int run_len, input bit poke, input bit expect_hold);
      int n, np, nz, nr, npost;
      hs_req  = 1'b1;
      data_lp = 1'b1;
      @(negedge clk);
      measure(C_IDLE, n);
      if (expect_hold) chk(n + 1 >= E_LPX, "R10 LP-11 hold before re-entry", n + 1, E_LPX);
      else             chk(n <= 2, "R1 start latency", n, 2);
      chk(cur() == C_LP01, "R1 LP-01 after LP-11", int'(cur()), int'(C_LP01));
      measure(C_LP01, n);
      chk(n == E_LPX && n * P >= 50000, "R2 LP-01 length", n, E_LPX);
      chk(cur() == C_PREP, "R1 LP-00 after LP-01", int'(cur()), int'(C_PREP));
      measure(C_PREP, np);
      chk(np == E_PREP && np * P >= 38000 && np * P <= 95000, "R3 prepare length", np, E_PREP);
      chk(cur() == C_HS0, "R1 HS-0 after prepare", int'(cur()), int'(C_HS0));
      measure(C_HS0, nz);
      chk(nz == E_ZERO && (np + nz) * P >= 300000, "R4 prepare+zero", np + nz, E_TOTZ);
      chk(cur() == C_CLK, "R1 clock after zero", int'(cur()), int'(C_CLK));
      measure(C_CLK, n);
      chk(n == E_PRE && n * P >= 8 * UI, "R5 clock-pre length", n, E_PRE);
      chk(cur() == C_RDY, "R5 ready after pre", int'(cur()), int'(C_RDY));
      // data lanes in HS
      data_lp = 1'b0;
      repeat (run_len) @(negedge clk);
      hs_req = 1'b0;
      repeat (4) @(negedge clk);
      chk(cur() == C_RDY, "R7 no exit while data lanes in HS", int'(cur()), int'(C_RDY));
      hs_req  = 1'b1;
      data_lp = 1'b1;
      repeat (4) @(negedge clk);
      chk(cur() == C_RDY, "R7 no exit while request held", int'(cur()), int'(C_RDY));
      // exit
      hs_req  = 1'b0;
      data_lp = 1'b1;
      @(negedge clk);
      measure(C_RDY, nr);
      chk(nr <= 1, "R6 ready drop latency", nr, 1);
      chk(cur() == C_CLK, "R6 clock without ready on exit", int'(cur()), int'(C_CLK));
      if (poke) hs_req = 1'b1;
      measure(C_CLK, npost);
      chk(npost == E_POST && (nr + npost + 1) * P >= 60000 + 52 * UI,
          "R8 clock-post length", npost, E_POST);
      chk(cur() == C_HS0, "R9 trail after post", int'(cur()), int'(C_HS0));
      if (poke) hs_req = 1'b0;
      measure(C_HS0, n);
      chk(n == E_TRAIL && n * P >= 60000, "R9 trail length", n, E_TRAIL);
      chk(cur() == C_IDLE, "R9 LP-11 after trail", int'(cur()), int'(C_IDLE));
      if (poke) begin
         bit stay = 1'b1;
         for (int i = 0; i < E_LPX + 12; i++) begin
            if (cur() != C_IDLE) stay = 1'b0;
            @(negedge clk);
         end
         chk(stay, "R11 request outside idle ignored", int'(cur()), int'(C_IDLE));
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_total++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

   initial begin
      hs_req = 1'b1;   // held across reset release
      repeat (3) @(negedge clk);
      chk(cur() == C_IDLE, "R10 LP-11 during reset", int'(cur()), int'(C_IDLE));
      rst_n = 1'b1;
      burst(3, 1'b0, 1'b1);
      burst(0, 1'b0, 1'b1);
      burst(17, 1'b1, 1'b1);
      burst(1, 1'b1, 1'b0);
      burst(40, 1'b0, 1'b0);
      burst(5, 1'b0, 1'b1);
      $display("%0d/%0d checks passed", n_total - n_fail, n_total);
      $finish;
   end

endmodule